// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block keeps a small set of hardware breakpoint and watchpoint triggers and checks one fetch, store or load operation against all of them at once. Each trigger carries a control word (which access kinds and which privilege levels it watches, whether it looks at the address or the data word, its compare mode and its chain bit) and a compare value as wide as a machine word. A configuration port writes one trigger per cycle.

A query presents the access kind, the address, the data word, the current privilege level, a flag for 32-bit operation and a flag saying the hart is already in debug mode. One cycle after a valid query the unit reports whether a trigger fired and, if so, the index of the lowest trigger that fired. Chained triggers let two or more adjacent triggers combine into one condition, such as an address range together with a data value. The unit only reports the hit. Acting on it (entering debug, tracing) is left to the logic around it.

Top module: `trig_match_unit`

## Requirements
- R1: `hit_valid` and `hit_index` are registered. They reflect the query presented in the previous cycle. After a cycle with `query_valid` low, and after a query that fires nothing, `hit_valid` is 0 and `hit_index` is 0.
- R2: A synchronous reset clears every trigger's control word and compare value. Until a trigger is written again, no query fires.
- R3: Access kind `query_op` is coded 0 execute, 1 store, 2 load. A trigger takes part only when its enable bit for that kind is set (`cfg_op_en` bit 0 execute, bit 1 store, bit 2 load). Code 3 never fires any trigger.
- R4: Privilege `query_priv` is coded 0 U, 1 S, 2 H, 3 M. A trigger takes part only when `cfg_priv_en[query_priv]` is set.
- R5: With its select bit set, a trigger compares the data word. With the bit clear, it compares the address.
- R6: When `query_is32` is 1, the compared operand is cut to its low 32 bits before any compare.
- R7: Mode 0 fires on exact equality with the compare value. Mode 2 fires when the operand is at least the compare value. Mode 3 fires when it is strictly below it. Modes 2 and 3 compare unsigned.
- R8: Mode 1 counts n, the run of ones starting at bit 0 of the compare value. It ignores the low n bits of both the operand and the compare value and fires when the remaining bits are equal. An all-ones value matches every operand.
- R9: Modes 4 and 5 form a mask by shifting the compare value right by half the word width: 16 when `query_is32` is 1, otherwise half of DATA_W. Mode 4 fires when (operand & mask) equals (compare & mask). Mode 5 fires when ((operand >> half) & mask) equals (compare & mask).
- R10: Mode codes 6 and 7 never match.
- R11: When several triggers fire, the lowest index is reported.
- R12: A matching trigger with its chain bit set does not fire by itself. A hit is reported at the first following matching trigger whose chain bit is clear. A chained last trigger never fires.
- R13: A chained trigger that does not match blocks every following trigger up to and including the next one whose chain bit is clear. Evaluation resumes after it.
- R14: While `query_in_debug` is 1, no trigger fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write one trigger's control word and compare value |
| cfg_index | input | IDX_W | Trigger being written |
| cfg_sel_data | input | 1 | 1: compare data word, 0: compare address |
| cfg_chain | input | 1 | Chain this trigger to the next one |
| cfg_mode | input | 3 | Compare mode code |
| cfg_priv_en | input | 4 | Privilege enables, bit n for privilege code n |
| cfg_op_en | input | 3 | Access-kind enables: execute, store, load |
| cfg_value | input | DATA_W | Compare value |
| query_valid | input | 1 | A query is presented this cycle |
| query_op | input | 2 | Access kind |
| query_addr | input | DATA_W | Access address |
| query_data | input | DATA_W | Access data word |
| query_priv | input | 2 | Current privilege level |
| query_is32 | input | 1 | Hart runs in 32-bit mode |
| query_in_debug | input | 1 | Hart already in debug mode |
| hit_valid | output | 1 | A trigger fired for last cycle's query |
| hit_index | output | IDX_W | Index of the trigger that fired |

## Verification
The bound checker watches, on every cycle, the rules that need no knowledge of the stored triggers. No hit follows an idle cycle, a query made in debug mode, or one with access code 3, and nothing fires before the first configuration write after reset. The compare modes, the privilege, access-kind and select filtering, the 32-bit cut, the priority order and both chaining rules depend on the trigger contents. Only the bench scenarios can show them, by programming triggers and comparing each result against an independent model.

// File: rtl/trig_pkg.sv
package trig_pkg;

   // compare mode codes; 6 and 7 are left unused and never match
   localparam logic [2:0] MODE_EQ   = 3'd0;
   localparam logic [2:0] MODE_POW2 = 3'd1;
   localparam logic [2:0] MODE_GE   = 3'd2;
   localparam logic [2:0] MODE_LT   = 3'd3;
   localparam logic [2:0] MODE_MLO  = 3'd4;
   localparam logic [2:0] MODE_MHI  = 3'd5;

   // access kinds
   localparam logic [1:0] OP_EXEC  = 2'd0;
   localparam logic [1:0] OP_STORE = 2'd1;
   localparam logic [1:0] OP_LOAD  = 2'd2;

   // narrow-mode word is 32 bits, so its half is 16
   localparam int NARROW_HALF = 16;

   typedef struct packed {
      logic       sel_data;
      logic       chain;
      logic [2:0] mode;
      logic [3:0] priv_en;
      logic [2:0] op_en;
   } trig_ctrl_t;

endpackage

// File: rtl/trig_cfg_store.sv
module trig_cfg_store
   import trig_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int DATA_W   = 64,
   parameter int IDX_W    = $clog2(NUM_TRIG)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 idx,
   input  trig_ctrl_t                       ctrl_in,
   input  logic [DATA_W-1:0]                value_in,
   output trig_ctrl_t [NUM_TRIG-1:0]        ctrl_q,
   output logic [NUM_TRIG-1:0][DATA_W-1:0]  value_q
);

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            ctrl_q[g]  <= '0;
            value_q[g] <= '0;
         end else if (we && (idx == IDX_W'(g))) begin
            ctrl_q[g]  <= ctrl_in;
            value_q[g] <= value_in;
         end
      end
   end

endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
   import trig_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  trig_ctrl_t        ctrl,
   input  logic [DATA_W-1:0] cmp_val,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        priv,
   input  logic              is32,
   output logic              match
);

   localparam int HALF = DATA_W / 2;
   localparam logic [DATA_W-1:0] LOW32 = DATA_W'(32'hFFFF_FFFF);

   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] plus1;
   logic [DATA_W-1:0] low_ones;
   logic [DATA_W-1:0] hmask;
   logic [DATA_W-1:0] opnd_hi;
   logic              op_ok;
   logic              priv_ok;
   logic              val_hit;

   always_comb begin
      opnd = ctrl.sel_data ? data : addr;
      if (is32) opnd = opnd & LOW32;

      // trailing-ones run of the compare value, as a bit mask
      plus1    = cmp_val + DATA_W'(1);
      low_ones = cmp_val & ~plus1;

      hmask   = is32 ? (cmp_val >> NARROW_HALF) : (cmp_val >> HALF);
      opnd_hi = is32 ? (opnd >> NARROW_HALF) : (opnd >> HALF);

      op_ok = ((op == OP_EXEC)  && ctrl.op_en[0]) ||
              ((op == OP_STORE) && ctrl.op_en[1]) ||
              ((op == OP_LOAD)  && ctrl.op_en[2]);
      priv_ok = ctrl.priv_en[priv];

      case (ctrl.mode)
         MODE_EQ:   val_hit = (opnd == cmp_val);
         MODE_POW2: val_hit = ((opnd & ~low_ones) == (cmp_val & ~low_ones));
         MODE_GE:   val_hit = (opnd >= cmp_val);
         MODE_LT:   val_hit = (opnd < cmp_val);
         MODE_MLO:  val_hit = ((opnd & hmask) == (cmp_val & hmask));
         MODE_MHI:  val_hit = ((opnd_hi & hmask) == (cmp_val & hmask));
         default:   val_hit = 1'b0;
      endcase

      match = op_ok && priv_ok && val_hit;
   end

endmodule

// File: rtl/trig_resolve.sv
module trig_resolve #(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = $clog2(NUM_TRIG)
) (
   input  logic [NUM_TRIG-1:0] match,
   input  logic [NUM_TRIG-1:0] chain,
   input  logic                in_debug,
   output logic                fire,
   output logic [IDX_W-1:0]    fire_idx
);

   logic chain_ok;
   logic found;

   always_comb begin
      chain_ok = 1'b1;
      found    = 1'b0;
      fire_idx = '0;
      for (int i = 0; i < NUM_TRIG; i++) begin
         if (!found) begin
            if (!chain_ok) begin
               // skipping the rest of a broken chain
               if (!chain[i]) chain_ok = 1'b1;
            end else if (match[i]) begin
               if (!chain[i]) begin
                  found    = 1'b1;
                  fire_idx = IDX_W'(i);
               end
            end else if (chain[i]) begin
               chain_ok = 1'b0;
            end
         end
      end
      fire = found && !in_debug;
   end

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
   import trig_pkg::*;
#(
   parameter int NUM_TRIG = 4,
   parameter int DATA_W   = 64,
   localparam int IDX_W   = $clog2(NUM_TRIG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_index,
   input  logic              cfg_sel_data,
   input  logic              cfg_chain,
   input  logic [2:0]        cfg_mode,
   input  logic [3:0]        cfg_priv_en,
   input  logic [2:0]        cfg_op_en,
   input  logic [DATA_W-1:0] cfg_value,
   input  logic              query_valid,
   input  logic [1:0]        query_op,
   input  logic [DATA_W-1:0] query_addr,
   input  logic [DATA_W-1:0] query_data,
   input  logic [1:0]        query_priv,
   input  logic              query_is32,
   input  logic              query_in_debug,
   output logic              hit_valid,
   output logic [IDX_W-1:0]  hit_index
);

   if (NUM_TRIG < 2) begin : g_bad_num
      $error("trig_match_unit: NUM_TRIG must be at least 2");
   end
   if ((DATA_W < 32) || ((DATA_W % 2) != 0)) begin : g_bad_width
      $error("trig_match_unit: DATA_W must be even and at least 32");
   end

   trig_ctrl_t                      wr_ctrl;
   trig_ctrl_t [NUM_TRIG-1:0]       ctrl_q;
   logic [NUM_TRIG-1:0][DATA_W-1:0] value_q;
   logic [NUM_TRIG-1:0]             match;
   logic [NUM_TRIG-1:0]             chain;
   logic                            fire;
   logic [IDX_W-1:0]                fire_idx;

   always_comb begin
      wr_ctrl.sel_data = cfg_sel_data;
      wr_ctrl.chain    = cfg_chain;
      wr_ctrl.mode     = cfg_mode;
      wr_ctrl.priv_en  = cfg_priv_en;
      wr_ctrl.op_en    = cfg_op_en;
   end

   trig_cfg_store #(
      .NUM_TRIG (NUM_TRIG),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W)
   ) i_store (
      .clk      (clk),
      .rst      (rst),
      .we       (cfg_we),
      .idx      (cfg_index),
      .ctrl_in  (wr_ctrl),
      .value_in (cfg_value),
      .ctrl_q   (ctrl_q),
      .value_q  (value_q)
   );

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_cmp
      assign chain[g] = ctrl_q[g].chain;
      trig_cmp #(
         .DATA_W (DATA_W)
      ) i_cmp (
         .ctrl    (ctrl_q[g]),
         .cmp_val (value_q[g]),
         .op      (query_op),
         .addr    (query_addr),
         .data    (query_data),
         .priv    (query_priv),
         .is32    (query_is32),
         .match   (match[g])
      );
   end

   trig_resolve #(
      .NUM_TRIG (NUM_TRIG),
      .IDX_W    (IDX_W)
   ) i_resolve (
      .match    (match),
      .chain    (chain),
      .in_debug (query_in_debug),
      .fire     (fire),
      .fire_idx (fire_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hit_valid <= 1'b0;
         hit_index <= '0;
      end else begin
         hit_valid <= query_valid && fire;
         hit_index <= (query_valid && fire) ? fire_idx : '0;
      end
   end

endmodule

// File: rtl/trig_match_unit_chk.sv
module trig_match_unit_chk #(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             cfg_we,
   input logic             query_valid,
   input logic [1:0]       query_op,
   input logic             query_in_debug,
   input logic             hit_valid,
   input logic [IDX_W-1:0] hit_index
);

   logic cfg_seen;

   always_ff @(posedge clk) begin
      if (rst)         cfg_seen <= 1'b0;
      else if (cfg_we) cfg_seen <= 1'b1;
   end

   // R1
   idle_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
      !query_valid |=> (!hit_valid && (hit_index == '0)));

   // R2
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_seen |=> !hit_valid);

   // R3
   bad_op_chk: assert property (@(posedge clk) disable iff (rst)
      (query_op == 2'd3) |=> !hit_valid);

   // R14
   debug_block_chk: assert property (@(posedge clk) disable iff (rst)
      query_in_debug |=> !hit_valid);

endmodule

bind trig_match_unit trig_match_unit_chk #(.IDX_W(IDX_W)) i_chk (
   .clk            (clk),
   .rst            (rst),
   .cfg_we         (cfg_we),
   .query_valid    (query_valid),
   .query_op       (query_op),
   .query_in_debug (query_in_debug),
   .hit_valid      (hit_valid),
   .hit_index      (hit_index)
);

// File: tb/test_trig_match_unit.sv
module test_trig_match_unit;

   localparam int NT = 4;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst;
   logic          cfg_we;
   logic [1:0]    cfg_index;
   logic          cfg_sel_data;
   logic          cfg_chain;
   logic [2:0]    cfg_mode;
   logic [3:0]    cfg_priv_en;
   logic [2:0]    cfg_op_en;
   logic [DW-1:0] cfg_value;
   logic          query_valid;
   logic [1:0]    query_op;
   logic [DW-1:0] query_addr;
   logic [DW-1:0] query_data;
   logic [1:0]    query_priv;
   logic          query_is32;
   logic          query_in_debug;
   logic          hit_valid;
   logic [1:0]    hit_index;

   always #5 clk = ~clk;

   trig_match_unit #(.NUM_TRIG(NT), .DATA_W(DW)) i_trig_match_unit (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_index(cfg_index),
      .cfg_sel_data(cfg_sel_data), .cfg_chain(cfg_chain), .cfg_mode(cfg_mode),
      .cfg_priv_en(cfg_priv_en), .cfg_op_en(cfg_op_en), .cfg_value(cfg_value),
      .query_valid(query_valid), .query_op(query_op), .query_addr(query_addr),
      .query_data(query_data), .query_priv(query_priv), .query_is32(query_is32),
      .query_in_debug(query_in_debug), .hit_valid(hit_valid), .hit_index(hit_index)
   );

   // mirror of the trigger contents, kept from the writes the bench makes
   logic          m_sel   [NT];
   logic          m_chain [NT];
   logic [2:0]    m_mode  [NT];
   logic [3:0]    m_priv  [NT];
   logic [2:0]    m_op    [NT];
   logic [DW-1:0] m_val   [NT];

   typedef struct {
      logic       v;
      logic [1:0] idx;
      string      req;
   } exp_t;
   exp_t sb[$];

   int  checks = 0;
   int  errors = 0;
   bit  done   = 0;

   function automatic logic trig_hit(int t, logic [1:0] op, logic [DW-1:0] a,
                                     logic [DW-1:0] d, logic [1:0] pv, logic n32);
      logic [DW-1:0] v, msk, hm, vh;
      int            run, h;
      logic          ok;
      if (op == 2'd3) return 1'b0;
      if (!m_op[t][op]) return 1'b0;
      if (!m_priv[t][pv]) return 1'b0;
      v = m_sel[t] ? d : a;
      if (n32) v = v & 64'h0000_0000_FFFF_FFFF;
      run = 0;
      while (run < DW && m_val[t][run]) run++;
      msk = '0;
      for (int b = 0; b < DW; b++) msk[b] = (b >= run);
      h  = n32 ? 16 : DW / 2;
      hm = m_val[t] >> h;
      vh = v >> h;
      case (m_mode[t])
         3'd0: ok = (v == m_val[t]);
         3'd1: ok = ((v & msk) == (m_val[t] & msk));
         3'd2: ok = !(v < m_val[t]);
         3'd3: ok = (v < m_val[t]);
         3'd4: ok = ((v & hm) == (m_val[t] & hm));
         3'd5: ok = ((vh & hm) == (m_val[t] & hm));
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

   function automatic logic [2:0] model(logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] d,
                                        logic [1:0] pv, logic n32, logic dbg);
      logic ok = 1'b1;
      if (dbg) return 3'b000;
      for (int t = 0; t < NT; t++) begin
         logic m;
         m = trig_hit(t, op, a, d, pv, n32);
         if (!ok) begin
            if (!m_chain[t]) ok = 1'b1;
         end else if (m) begin
            if (!m_chain[t]) return {1'b1, 2'(t)};
         end else if (m_chain[t]) begin
            ok = 1'b0;
         end
      end
      return 3'b000;
   endfunction

   task automatic idle_in();
      cfg_we      = 1'b0;
      query_valid = 1'b0;
      query_op    = 2'd0;
      query_addr  = '0;
      query_data  = '0;
      query_priv  = 2'd3;
      query_is32  = 1'b0;
      query_in_debug = 1'b0;
   endtask

   task automatic cfg(int t, logic sel, logic ch, logic [2:0] mode,
                      logic [3:0] pv, logic [2:0] ope, logic [DW-1:0] val);
      @(negedge clk);
      idle_in();
      cfg_we       = 1'b1;
      cfg_index    = 2'(t);
      cfg_sel_data = sel;
      cfg_chain    = ch;
      cfg_mode     = mode;
      cfg_priv_en  = pv;
      cfg_op_en    = ope;
      cfg_value    = val;
      @(posedge clk);
      m_sel[t] = sel; m_chain[t] = ch; m_mode[t] = mode;
      m_priv[t] = pv; m_op[t] = ope; m_val[t] = val;
   endtask

   task automatic clear_all();
      for (int t = 0; t < NT; t++) cfg(t, 0, 0, 3'd0, 4'h0, 3'b000, '0);
   endtask

   task automatic query(logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] d,
                        logic [1:0] pv, logic n32, logic dbg, string req);
      logic [2:0] e;
      exp_t       it;
      @(negedge clk);
      idle_in();
      query_valid    = 1'b1;
      query_op       = op;
      query_addr     = a;
      query_data     = d;
      query_priv     = pv;
      query_is32     = n32;
      query_in_debug = dbg;
      @(posedge clk);
      e = model(op, a, d, pv, n32, dbg);
      it.v = e[2]; it.idx = e[1:0]; it.req = req;
      sb.push_back(it);
   endtask

   task automatic idle_cycle(string req);
      exp_t it;
      @(negedge clk);
      idle_in();
      @(posedge clk);
      it.v = 1'b0; it.idx = 2'd0; it.req = req;
      sb.push_back(it);
   endtask

   // monitor: results appear in the cycle after the query's edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (hit_valid !== e.v || hit_index !== e.idx) begin
            errors++;
            $display("FAIL %s: hit_valid=%0b hit_index=%0d expected hit_valid=%0b hit_index=%0d",
                     e.req, hit_valid, hit_index, e.v, e.idx);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < NT; t++) begin
         m_sel[t] = 0; m_chain[t] = 0; m_mode[t] = 0;
         m_priv[t] = 0; m_op[t] = 0; m_val[t] = '0;
      end
      idle_in();
      cfg_index = 0; cfg_sel_data = 0; cfg_chain = 0; cfg_mode = 0;
      cfg_priv_en = 0; cfg_op_en = 0; cfg_value = '0;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (hit_valid !== 1'b0 || hit_index !== 2'd0) begin
         errors++;
         $display("FAIL R2: reset hit_valid=%0b hit_index=%0d expected 0 0", hit_valid, hit_index);
      end
      rst = 1'b0;

      // R1 idle, R2 nothing configured
      idle_cycle("R1");
      query(2'd0, 64'h0, 64'h0, 2'd3, 0, 0, "R2");
      query(2'd2, 64'h0, 64'h0, 2'd0, 0, 0, "R2");

      // R7 equal, R3 access kind filter
      cfg(0, 0, 0, 3'd0, 4'hF, 3'b001, 64'h1000);
      query(2'd0, 64'h1000, 64'h0, 2'd3, 0, 0, "R7");
      query(2'd2, 64'h1000, 64'h0, 2'd3, 0, 0, "R3");
      query(2'd3, 64'h1000, 64'h0, 2'd3, 0, 0, "R3");
      idle_cycle("R1");
      query(2'd0, 64'h1001, 64'h0, 2'd3, 0, 0, "R7");

      // R4 privilege
      cfg(0, 0, 0, 3'd0, 4'b1000, 3'b001, 64'h1000);
      query(2'd0, 64'h1000, 64'h0, 2'd0, 0, 0, "R4");
      query(2'd0, 64'h1000, 64'h0, 2'd3, 0, 0, "R4");
      cfg(0, 0, 0, 3'd0, 4'b0010, 3'b001, 64'h1000);
      query(2'd0, 64'h1000, 64'h0, 2'd1, 0, 0, "R4");
      query(2'd0, 64'h1000, 64'h0, 2'd2, 0, 0, "R4");

      // R5 select
      clear_all();
      cfg(1, 1, 0, 3'd0, 4'hF, 3'b010, 64'hDEAD);
      query(2'd1, 64'hDEAD, 64'h0, 2'd3, 0, 0, "R5");
      query(2'd1, 64'h0, 64'hDEAD, 2'd3, 0, 0, "R5");

      // R6 32-bit cut
      cfg(1, 1, 0, 3'd0, 4'hF, 3'b010, 64'h1234_5678);
      query(2'd1, 64'h0, 64'hFFFF_FFFF_1234_5678, 2'd3, 1, 0, "R6");
      query(2'd1, 64'h0, 64'hFFFF_FFFF_1234_5678, 2'd3, 0, 0, "R6");

      // R7 unsigned ge / lt
      clear_all();
      cfg(2, 0, 0, 3'd2, 4'hF, 3'b100, 64'h100);
      query(2'd2, 64'h100, 64'h0, 2'd3, 0, 0, "R7");
      query(2'd2, 64'hFF, 64'h0, 2'd3, 0, 0, "R7");
      query(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd3, 0, 0, "R7");
      cfg(2, 0, 0, 3'd3, 4'hF, 3'b100, 64'h100);
      query(2'd2, 64'hFF, 64'h0, 2'd3, 0, 0, "R7");
      query(2'd2, 64'h100, 64'h0, 2'd3, 0, 0, "R7");

      // R8 power-of-two range
      cfg(2, 0, 0, 3'd1, 4'hF, 3'b100, 64'h2000_00FF);
      query(2'd2, 64'h2000_0012, 64'h0, 2'd3, 0, 0, "R8");
      query(2'd2, 64'h2000_0112, 64'h0, 2'd3, 0, 0, "R8");
      cfg(2, 0, 0, 3'd1, 4'hF, 3'b100, 64'hFFFF_FFFF_FFFF_FFFF);
      query(2'd2, 64'h1234_0000_9876_5432, 64'h0, 2'd3, 0, 0, "R8");

      // R9 mask modes
      cfg(2, 0, 0, 3'd4, 4'hF, 3'b100, 64'h0000_FF00_0000_1200);
      query(2'd2, 64'h5555_5555_0000_12AB, 64'h0, 2'd3, 0, 0, "R9");
      query(2'd2, 64'h5555_5555_0000_13AB, 64'h0, 2'd3, 0, 0, "R9");
      cfg(2, 0, 0, 3'd5, 4'hF, 3'b100, 64'h0000_FFFF_0000_ABCD);
      query(2'd2, 64'h0000_ABCD_9999_9999, 64'h0, 2'd3, 0, 0, "R9");
      query(2'd2, 64'h0000_ABCE_9999_9999, 64'h0, 2'd3, 0, 0, "R9");
      cfg(2, 0, 0, 3'd4, 4'hF, 3'b100, 64'h0000_0000_0F0F_0005);
      query(2'd2, 64'h0000_0000_0000_0105, 64'h0, 2'd3, 0, 0, "R9");
      query(2'd2, 64'h0000_0000_0000_0005, 64'h0, 2'd3, 1, 0, "R9");
      query(2'd2, 64'h0000_0000_0000_0105, 64'h0, 2'd3, 1, 0, "R9");

      // R10 unused mode codes
      cfg(2, 0, 0, 3'd6, 4'hF, 3'b111, 64'h0);
      query(2'd2, 64'h0, 64'h0, 2'd3, 0, 0, "R10");
      cfg(2, 0, 0, 3'd7, 4'hF, 3'b111, 64'h0);
      query(2'd0, 64'h0, 64'h0, 2'd3, 0, 0, "R10");

      // R11 priority, back to back queries
      clear_all();
      cfg(3, 0, 0, 3'd0, 4'hF, 3'b001, 64'h40);
      cfg(1, 0, 0, 3'd0, 4'hF, 3'b001, 64'h40);
      query(2'd0, 64'h40, 64'h0, 2'd3, 0, 0, "R11");
      cfg(0, 0, 0, 3'd2, 4'hF, 3'b001, 64'h0);
      query(2'd0, 64'h40, 64'h0, 2'd3, 0, 0, "R11");
      query(2'd0, 64'h41, 64'h0, 2'd3, 0, 0, "R11");

      // R12 / R13 chaining
      clear_all();
      cfg(0, 0, 1, 3'd0, 4'hF, 3'b001, 64'h40);
      cfg(1, 1, 0, 3'd0, 4'hF, 3'b001, 64'h77);
      cfg(2, 0, 0, 3'd2, 4'hF, 3'b001, 64'h0);
      query(2'd0, 64'h40, 64'h77, 2'd3, 0, 0, "R12");
      query(2'd0, 64'h40, 64'h00, 2'd3, 0, 0, "R12");
      query(2'd0, 64'h41, 64'h77, 2'd3, 0, 0, "R13");
      cfg(2, 0, 0, 3'd2, 4'h0, 3'b000, 64'h0);
      query(2'd0, 64'h41, 64'h77, 2'd3, 0, 0, "R13");
      clear_all();
      cfg(3, 0, 1, 3'd2, 4'hF, 3'b001, 64'h0);
      query(2'd0, 64'h41, 64'h0, 2'd3, 0, 0, "R12");

      // R14 debug mode
      cfg(3, 0, 0, 3'd2, 4'hF, 3'b001, 64'h0);
      query(2'd0, 64'h41, 64'h0, 2'd3, 0, 1, "R14");
      query(2'd0, 64'h41, 64'h0, 2'd3, 0, 0, "R14");

      // R2 reset clears configured triggers
      @(negedge clk);
      idle_in();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int t = 0; t < NT; t++) begin
         m_sel[t] = 0; m_chain[t] = 0; m_mode[t] = 0;
         m_priv[t] = 0; m_op[t] = 0; m_val[t] = '0;
      end
      query(2'd0, 64'h41, 64'h0, 2'd3, 0, 0, "R2");

      idle_cycle("R1");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule